// File: doc/BRIEF.md
# Programmable Interrupt Controller with Software Self-Test

The block gathers a parameterised number of interrupt lines into one request output. Software programs it through a simple single-cycle register port: `wr_en` with `addr` and `wdata` for writes, and a registered `rdata` that always shows the register selected by `addr` one clock earlier. Each input line is captured as either a rising edge or an active-high level, chosen per line by a parameter mask. A captured event is held in a status bit until software clears it with an acknowledge write.

After reset the controller is in a self-test state. The hardware lines are ignored, and software can raise interrupts by writing ones into the status register. Setting the arm bit in the control register switches to the hardware lines for good, until the next reset. A per-line enable mask, with separate set and clear aliases, selects which recorded events are pending. A vector register gives the lowest-numbered pending line. A master bit gates the single request output.

Register offsets: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C control. The control register has bit 0 = request enable and bit 1 = hardware arm.

Top module: `intr_ctrl_top`

## Requirements
- R1: After reset, status, enable and control are all zero, `irq_out` is low, and the vector register (0x18) reads all ones.
- R2: While the arm bit (control bit 1) is 0, the hardware input lines do not change status. Writing to status (0x00) sets every status bit written as 1 and leaves the bits written as 0 unchanged.
- R3: Once the arm bit is 1, input events set status bits, and writes to status (0x00) no longer set any bit.
- R4: The arm bit can only be set. Any later write to control (0x1C), including one with bit 1 = 0, leaves it at 1 until reset. Bit 0 follows each write to control.
- R5: Pending (0x04) reads the bitwise AND of status and enable.
- R6: The vector register (0x18) reads the index of the lowest-numbered pending line, so line 0 has the highest priority.
- R7: The vector register reads all ones whenever no line is pending.
- R8: Writing 1s to acknowledge (0x0C) clears those status bits. Acknowledge reads 0. A level line that is still high sets its status bit again on the next clock.
- R9: An edge line sets status only on a low-to-high change between two clocks, so a line held high does not set status again after acknowledge. When an event and an acknowledge of the same bit fall in the same cycle, the event wins.
- R10: Clearing an enable bit does not clear the matching status bit. The event stays recorded and becomes pending again when re-enabled.
- R11: Writing to enable (0x08) loads the whole mask. Writing 1s to set-enable (0x10) sets those bits, and writing 1s to clear-enable (0x14) clears those bits. All other bits are left as they were. Both aliases read 0.
- R12: `irq_out` is registered. It is high one clock after a state in which control bit 0 is 1 and at least one line is pending, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IN | Interrupt input lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the previous cycle's addr |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A write or an input event presented before clock edge k changes the internal state at edge k. `irq_out` and any read of that state then follow at edge k+1, and `rdata` always shows the register addressed before that same edge. The bench model updates its state at each rising edge in the same order: capture event, apply the write, register the outputs from the old state. The bench compares `irq_out` and `rdata` at every falling edge. The named checks drive the address one falling edge early and sample on the next, so each check lands exactly one register stage after the state it inspects.

// File: rtl/intr_pkg.sv
package intr_pkg;
  // register byte offsets
  localparam int OFS_STAT = 'h00;
  localparam int OFS_PEND = 'h04;
  localparam int OFS_EN   = 'h08;
  localparam int OFS_ACK  = 'h0C;
  localparam int OFS_SETE = 'h10;
  localparam int OFS_CLRE = 'h14;
  localparam int OFS_VEC  = 'h18;
  localparam int OFS_CTRL = 'h1C;
  // control register bit positions
  localparam int CTRL_REQ_BIT = 0;
  localparam int CTRL_ARM_BIT = 1;

  typedef struct packed {
    logic arm;
    logic req_en;
  } ctrl_t;
endpackage

// File: rtl/intr_capture.sv
module intr_capture #(
  parameter int N_IN = 8,
  parameter logic [N_IN-1:0] EDGE_MASK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm,
  input  logic [N_IN-1:0] raw,
  output logic [N_IN-1:0] ev
);
  for (genvar i = 0; i < N_IN; i++) begin : g_line
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= raw[i];
      end
      assign ev[i] = arm & raw[i] & ~prev_q;
    end else begin : g_level
      assign ev[i] = arm & raw[i];
    end
  end
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_IN-1:0]   ev,
  output logic [N_IN-1:0]   status,
  output logic [N_IN-1:0]   enable,
  output ctrl_t             ctrl
);
  logic [N_IN-1:0] sw_set, ack_clr, status_n, enable_n;
  ctrl_t           ctrl_n;
  logic [N_IN-1:0] wbits;

  assign wbits = wdata[N_IN-1:0];

  function automatic logic hit(input logic w, input logic [ADDR_W-1:0] a, input int ofs);
    return w && (a == ADDR_W'(ofs));
  endfunction

  always_comb begin
    sw_set   = (hit(wr_en, addr, OFS_STAT) && !ctrl.arm) ? wbits : '0;
    ack_clr  = hit(wr_en, addr, OFS_ACK) ? wbits : '0;
    status_n = ((status | sw_set) & ~ack_clr) | ev;

    enable_n = enable;
    if (hit(wr_en, addr, OFS_EN))   enable_n = wbits;
    if (hit(wr_en, addr, OFS_SETE)) enable_n = enable | wbits;
    if (hit(wr_en, addr, OFS_CLRE)) enable_n = enable & ~wbits;

    ctrl_n = ctrl;
    if (hit(wr_en, addr, OFS_CTRL)) begin
      ctrl_n.req_en = wdata[CTRL_REQ_BIT];
      ctrl_n.arm    = ctrl.arm | wdata[CTRL_ARM_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      ctrl   <= '0;
    end else begin
      status <= status_n;
      enable <= enable_n;
      ctrl   <= ctrl_n;
    end
  end

  // R4
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl.arm) |-> ctrl.arm);

  // R10
  mask_keeps_status_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(status) & ~$past(ack_clr) & ~status) == '0));

  // R3
  no_sw_set_armed_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl.arm) && $past(ev) == '0) |-> ((status & ~$past(status)) == '0));
endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
  parameter int N_IN   = 8,
  parameter int DATA_W = 32
) (
  input  logic [N_IN-1:0]   pend,
  output logic [DATA_W-1:0] vec
);
  always_comb begin
    vec = '1;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (pend[i]) vec = DATA_W'(i);
    end
  end
endmodule

// File: rtl/intr_ctrl_top.sv
module intr_ctrl_top
  import intr_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter logic [N_IN-1:0] EDGE_MASK = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   irq_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out
);
  logic [N_IN-1:0]   ev, status, enable, pend;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] vec, rd_n;

  intr_capture #(.N_IN(N_IN), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk(clk), .rst(rst), .arm(ctrl.arm), .raw(irq_in), .ev(ev));

  intr_regs #(.N_IN(N_IN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ev(ev), .status(status), .enable(enable), .ctrl(ctrl));

  assign pend = status & enable;

  intr_prio #(.N_IN(N_IN), .DATA_W(DATA_W)) u_prio (.pend(pend), .vec(vec));

  always_comb begin
    rd_n = '0;
    case (addr)
      ADDR_W'(OFS_STAT): rd_n = DATA_W'(status);
      ADDR_W'(OFS_PEND): rd_n = DATA_W'(pend);
      ADDR_W'(OFS_EN):   rd_n = DATA_W'(enable);
      ADDR_W'(OFS_VEC):  rd_n = vec;
      ADDR_W'(OFS_CTRL): rd_n = DATA_W'(ctrl);
      default:           rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_out <= 1'b0;
    end else begin
      rdata   <= rd_n;
      irq_out <= ctrl.req_en & (|pend);
    end
  end

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(ctrl.req_en) && $past(pend) != '0));

  // R7
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_W'(OFS_VEC) && $past(pend) == '0) |-> (rdata == '1));
endmodule

// File: tb/test_intr_ctrl_top.sv
module test_intr_ctrl_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [N-1:0] EDGE = 8'hF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string phase = "R1";

  intr_ctrl_top #(.N_IN(N), .ADDR_W(AW), .DATA_W(DW), .EDGE_MASK(EDGE)) i_intr_ctrl_top (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit m_st[N], m_en[N], m_prev[N];
  bit m_req, m_arm, m_irq;
  logic [DW-1:0] m_rd;

  always @(posedge clk) begin
    bit evs[N];
    int first;
    int a;
    if (rst) begin
      foreach (m_st[i]) begin m_st[i] = 0; m_en[i] = 0; m_prev[i] = 0; end
      m_req = 0; m_arm = 0; m_irq = 0; m_rd = '0;
    end else begin
      a = int'(addr);
      first = -1;
      m_irq = 0;
      for (int i = 0; i < N; i++) begin
        if (m_st[i] && m_en[i]) begin
          m_irq = m_req;
          if (first < 0) first = i;
        end
      end
      m_rd = '0;
      for (int i = 0; i < N; i++) begin
        if (a == 'h00) m_rd[i] = m_st[i];
        if (a == 'h04) m_rd[i] = m_st[i] && m_en[i];
        if (a == 'h08) m_rd[i] = m_en[i];
      end
      if (a == 'h18) m_rd = (first < 0) ? '1 : DW'(first);
      if (a == 'h1C) m_rd = {30'd0, m_arm, m_req};
      for (int i = 0; i < N; i++)
        evs[i] = m_arm && irq_in[i] && (EDGE[i] ? !m_prev[i] : 1'b1);
      for (int i = 0; i < N; i++) begin
        if (wr_en && a == 'h00 && !m_arm && wdata[i]) m_st[i] = 1;
        if (wr_en && a == 'h0C && wdata[i]) m_st[i] = 0;
        if (evs[i]) m_st[i] = 1;
        if (wr_en && a == 'h08) m_en[i] = wdata[i];
        if (wr_en && a == 'h10 && wdata[i]) m_en[i] = 1;
        if (wr_en && a == 'h14 && wdata[i]) m_en[i] = 0;
        m_prev[i] = irq_in[i];
      end
      if (wr_en && a == 'h1C) begin
        m_req = wdata[0];
        if (wdata[1]) m_arm = 1;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (irq_out !== m_irq || rdata !== m_rd) begin
        bad++;
        $display("FAIL %s per-clock: irq act=%0b exp=%0b rdata act=%h exp=%h",
                 phase, irq_out, m_irq, rdata, m_rd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check_val(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic chk_rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    check_val(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    phase = "R1";
    idle(1);
    check_val("R1 irq", {31'd0, irq_out}, 0);
    chk_rd('h18, '1, "R1 vector");
    chk_rd('h1C, 0, "R1 ctrl");
    // R2 hardware lines ignored, software sets status
    phase = "R2";
    irq_in = 8'h11; idle(3); irq_in = '0;
    chk_rd('h00, 0, "R2 hw ignored");
    wr('h00, 8'h08);
    wr('h00, 8'h00);
    chk_rd('h00, 8'h08, "R2 sw set");
    // R11 enable aliases
    phase = "R11";
    wr('h10, 8'h09);
    wr('h14, 8'h01);
    chk_rd('h08, 8'h08, "R11 set/clear");
    chk_rd('h10, 0, "R11 alias reads 0");
    wr('h08, 8'hFF);
    chk_rd('h08, 8'hFF, "R11 full load");
    // R5 pending
    phase = "R5";
    chk_rd('h04, 8'h08, "R5 pending");
    // R12 request gating
    phase = "R12";
    check_val("R12 gated off", {31'd0, irq_out}, 0);
    wr('h1C, 1);
    idle(1);
    check_val("R12 asserted", {31'd0, irq_out}, 1);
    // R6 priority
    phase = "R6";
    chk_rd('h18, 3, "R6 only line 3");
    wr('h00, 8'h01);
    chk_rd('h18, 0, "R6 line 0 wins");
    // R10 masking keeps status
    phase = "R10";
    wr('h14, 8'h01);
    chk_rd('h00, 8'h09, "R10 status kept");
    chk_rd('h18, 3, "R10 masked skipped");
    wr('h10, 8'h01);
    chk_rd('h18, 0, "R10 re-enabled");
    // R8 acknowledge, R7 idle vector
    phase = "R8";
    wr('h0C, 8'h09);
    chk_rd('h00, 0, "R8 ack clears");
    chk_rd('h0C, 0, "R8 ack reads 0");
    phase = "R7";
    chk_rd('h18, '1, "R7 idle vector");
    check_val("R12 dropped", {31'd0, irq_out}, 0);
    // R3 arm, R4 sticky
    phase = "R3";
    wr('h1C, 3);
    wr('h00, 8'h02);
    chk_rd('h00, 0, "R3 sw set blocked");
    phase = "R4";
    wr('h1C, 1);
    chk_rd('h1C, 3, "R4 arm kept");
    wr('h1C, 0);
    chk_rd('h1C, 2, "R4 arm kept, req follows");
    wr('h1C, 3);
    // R8 level re-set
    phase = "R8";
    irq_in = 8'h04; idle(3);
    chk_rd('h00, 8'h04, "R3 level captured");
    wr('h0C, 8'h04);
    chk_rd('h00, 8'h04, "R8 level sets again");
    irq_in = '0;
    wr('h0C, 8'h04);
    chk_rd('h00, 0, "R8 level cleared");
    // R9 edge lines
    phase = "R9";
    irq_in = 8'h10; idle(2);
    chk_rd('h00, 8'h10, "R9 edge captured");
    wr('h0C, 8'h10);
    idle(2);
    chk_rd('h00, 0, "R9 held high no re-set");
    irq_in = '0; idle(1);
    @(negedge clk);
    irq_in = 8'h10; wr_en = 1'b1; addr = AW'('h0C); wdata = 8'h10;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    chk_rd('h00, 8'h10, "R9 event beats ack");
    irq_in = 8'h70; idle(2);
    chk_rd('h18, 4, "R6 mixed lines");
    irq_in = '0; idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule